// File: doc/BRIEF.md
# Sub-word register write coalescing bridge

This bridge sits between a host bus that issues byte, halfword and word register accesses and a peripheral register file that only takes aligned 32-bit accesses. Narrow reads fetch the aligned word and return only the addressed lane. Narrow writes become a full word, either by read-modify-write or by merging into a held word.

Some peripherals sit across a clock crossing and can lose two writes that arrive too close together. For these, halfword writes to the block-size, block-count and transfer-mode registers are held in two shadow words and are not sent downstream. A halfword command write then releases them. The block word goes out first, but only if it is nonzero, and is then cleared. The command word, merged with the held transfer mode, goes out second. After every downstream write the bridge leaves the downstream port quiet for a spacing gap. The gap is computed from the card clock frequency.

Both ports use valid/ready. An upstream request is taken in a cycle with `req_valid` and `req_ready` both high. `req_ready` is high only when the bridge is idle, so the host must hold its request until it is taken. A downstream request is held stable until `dn_ready` is high. Read data returns on `dn_rvalid` after any latency. The upstream read response is a one-cycle `rsp_valid` pulse with no back-pressure.

Top module: `subword_wr_bridge`

## Requirements
- R1: After reset both shadow words are zero, `req_ready` is 1, and `dn_valid` and `rsp_valid` are 0. A first command write therefore produces a single downstream write whose only nonzero lane is the command halfword.
- R2: A read of any size (`req_size` 0 byte, 1 halfword, 2 word) issues one downstream read at the address with bits [1:0] cleared. It then pulses `rsp_valid` with the downstream word shifted right by 8×addr[1:0] and masked to the access width.
- R3: A halfword write to the block-size or block-count offset causes no downstream access and leaves `req_ready` high. Its value replaces lane 8×addr[1:0] of the block shadow word.
- R4: A halfword write to the transfer-mode offset causes no downstream access. Its value replaces its lane of the command shadow word.
- R5: A halfword command write while the block shadow is nonzero first writes the block shadow downstream at the aligned block-size address and clears the shadow. It then performs the command write of R6.
- R6: A halfword command write sends one downstream write at its aligned address. The data is the command shadow word with the command lane replaced. The command shadow itself keeps its value. With a zero block shadow, this is the only downstream write.
- R7: Every byte write, and every halfword write to an offset that is not shadowed, reads the aligned word, replaces only the addressed lane, and writes the full word back.
- R8: A word write is passed downstream unchanged as a single write.
- R9: After each accepted downstream write, `dn_valid` stays low for at least N×CYC_PER_US cycles. N = ceil(4000 / card_khz) when 0 < card_khz ≤ 400, N = 10 when card_khz = 0, and there is no gap above 400 kHz.
- R10: `req_ready` is low from the cycle after a read or sequenced write is taken until the sequence ends. A downstream request keeps valid, address, direction and data stable until it is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Upstream request valid |
| req_ready | output | 1 | Upstream request taken when high with req_valid |
| req_write | input | 1 | 1 write, 0 read |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_addr | input | AW | Byte address, aligned to the access size |
| req_wdata | input | 32 | Write value, right-justified |
| rsp_valid | output | 1 | Read response pulse |
| rsp_rdata | output | 32 | Read value, right-justified |
| dn_valid | output | 1 | Downstream request valid |
| dn_ready | input | 1 | Downstream request taken |
| dn_write | output | 1 | Downstream direction, 1 write |
| dn_addr | output | AW | Downstream aligned address |
| dn_wdata | output | 32 | Downstream write word |
| dn_rvalid | input | 1 | Downstream read data valid |
| dn_rdata | input | 32 | Downstream read word |
| card_khz | input | KHZ_W | Card clock frequency in kHz, sampled at each downstream write |

## Verification
The bench builds the bridge with an 8-bit address, the default register offsets and CYC_PER_US = 2. With these values a 10 µs gap is 20 cycles, so several hundred random operations fit in the run. The bench switches card_khz among 0, 100, 300, 400, 401 and 1000. This exercises the fixed gap, exact and rounded-up microsecond counts, the 400 kHz edge and the no-gap case. Random addresses over 64 words often land on the shadowed offsets and on non-shadowed neighbours in the same words.

// File: rtl/sbw_pkg.sv
package sbw_pkg;
  localparam int unsigned DW = 32;

  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2} size_e;
  typedef enum logic [2:0] {S_IDLE, S_RDREQ, S_RDWAIT, S_WRREQ, S_GAP} st_e;

  function automatic logic [4:0] lane_shift(input logic [1:0] lane);
    return {lane, 3'b000};
  endfunction

  function automatic logic [DW-1:0] size_mask(input size_e sz);
    case (sz)
      SZ_BYTE: return 32'h0000_00ff;
      SZ_HALF: return 32'h0000_ffff;
      default: return 32'hffff_ffff;
    endcase
  endfunction

  // replace one lane of a word
  function automatic logic [DW-1:0] merge_lane(input logic [DW-1:0] base,
                                              input logic [DW-1:0] val,
                                              input logic [1:0] lane,
                                              input size_e sz);
    logic [DW-1:0] m;
    m = size_mask(sz) << lane_shift(lane);
    return (base & ~m) | ((val & size_mask(sz)) << lane_shift(lane));
  endfunction

  function automatic logic [DW-1:0] pick_lane(input logic [DW-1:0] word,
                                             input logic [1:0] lane,
                                             input size_e sz);
    return (word >> lane_shift(lane)) & size_mask(sz);
  endfunction
endpackage

// File: rtl/sbw_shadow.sv
module sbw_shadow
  import sbw_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          blk_we,
  input  logic          cmd_we,
  input  logic          blk_clr,
  input  logic [1:0]    lane,
  input  logic [DW-1:0] val,
  output logic [DW-1:0] blk_q,
  output logic [DW-1:0] cmd_q,
  output logic [DW-1:0] cmd_next
);
  logic [DW-1:0] blk_next;

  always_comb begin
    blk_next = merge_lane(blk_q, val, lane, SZ_HALF);
    cmd_next = merge_lane(cmd_q, val, lane, SZ_HALF);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_q <= '0;
      cmd_q <= '0;
    end else begin
      if (blk_clr)     blk_q <= '0;
      else if (blk_we) blk_q <= blk_next;
      if (cmd_we)      cmd_q <= cmd_next;
    end
  end
endmodule

// File: rtl/sbw_gap_timer.sv
module sbw_gap_timer #(
  parameter int unsigned CYC_PER_US  = 100,
  parameter int unsigned KHZ_W       = 16,
  parameter int unsigned SLOW_KHZ    = 400,
  parameter int unsigned GAP_PERIODS = 4,
  parameter int unsigned ZERO_KHZ_US = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [KHZ_W-1:0] khz,
  output logic             busy
);
  localparam int unsigned PW  = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;
  localparam int unsigned UW  = $clog2(ZERO_KHZ_US + 1);
  localparam int unsigned TH  = GAP_PERIODS * 1000;
  localparam int unsigned ACW = 32;

  logic [PW-1:0]    presc;
  logic [UW-1:0]    us_cnt;
  logic [ACW-1:0]   acc;
  logic [KHZ_W-1:0] f_q;
  logic             tick, fin;

  always_comb begin
    tick = (presc == PW'(CYC_PER_US - 1));
    if (f_q == '0) fin = (us_cnt == UW'(ZERO_KHZ_US - 1));
    else           fin = ((acc + ACW'(f_q)) >= ACW'(TH));
  end

  // elapsed microseconds n grow until n*f reaches the period budget
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      presc  <= '0;
      us_cnt <= '0;
      acc    <= '0;
      f_q    <= '0;
    end else if (start) begin
      busy   <= (khz <= KHZ_W'(SLOW_KHZ));
      f_q    <= khz;
      presc  <= '0;
      us_cnt <= '0;
      acc    <= '0;
    end else if (busy) begin
      if (tick) begin
        presc  <= '0;
        us_cnt <= us_cnt + 1'b1;
        acc    <= acc + ACW'(f_q);
        if (fin) busy <= 1'b0;
      end else begin
        presc <= presc + 1'b1;
      end
    end
  end
endmodule

// File: rtl/subword_wr_bridge.sv
module subword_wr_bridge
  import sbw_pkg::*;
#(
  parameter int unsigned AW            = 8,
  parameter int unsigned KHZ_W         = 16,
  parameter int unsigned CYC_PER_US    = 100,
  parameter int unsigned SLOW_KHZ      = 400,
  parameter int unsigned GAP_PERIODS   = 4,
  parameter int unsigned ZERO_KHZ_US   = 10,
  parameter int unsigned BLK_SIZE_OFS  = 'h04,
  parameter int unsigned BLK_CNT_OFS   = 'h06,
  parameter int unsigned XFER_MODE_OFS = 'h0C,
  parameter int unsigned COMMAND_OFS   = 'h0E
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [1:0]       req_size,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  output logic             rsp_valid,
  output logic [DW-1:0]    rsp_rdata,
  output logic             dn_valid,
  input  logic             dn_ready,
  output logic             dn_write,
  output logic [AW-1:0]    dn_addr,
  output logic [DW-1:0]    dn_wdata,
  input  logic             dn_rvalid,
  input  logic [DW-1:0]    dn_rdata,
  input  logic [KHZ_W-1:0] card_khz
);
  localparam logic [AW-1:0] LOW2  = AW'(3);
  localparam logic [AW-1:0] BS_A  = AW'(BLK_SIZE_OFS);
  localparam logic [AW-1:0] BC_A  = AW'(BLK_CNT_OFS);
  localparam logic [AW-1:0] TM_A  = AW'(XFER_MODE_OFS);
  localparam logic [AW-1:0] CM_A  = AW'(COMMAND_OFS);
  localparam logic [AW-1:0] BS_AL = BS_A & ~LOW2;
  localparam logic [AW-1:0] CM_AL = CM_A & ~LOW2;

  st_e           st;
  size_e         sz_in, op_size;
  logic [AW-1:0] op_addr, align;
  logic [1:0]    op_lane;
  logic [DW-1:0] op_wdata, nxt_data;
  logic          op_rmw, nxt_pend;
  logic          accept, is_half, hit_blk, hit_tm, hit_cmd;
  logic          blk_we, cmd_we, blk_clr, gap_start, gap_busy;
  logic [DW-1:0] blk_q, cmd_q, cmd_next;

  always_comb begin
    sz_in     = size_e'(req_size);
    align     = req_addr & ~LOW2;
    accept    = req_valid && (st == S_IDLE);
    is_half   = req_write && (sz_in == SZ_HALF);
    hit_blk   = is_half && ((req_addr == BS_A) || (req_addr == BC_A));
    hit_tm    = is_half && (req_addr == TM_A);
    hit_cmd   = is_half && (req_addr == CM_A);
    blk_we    = accept && hit_blk;
    cmd_we    = accept && hit_tm;
    blk_clr   = accept && hit_cmd && (blk_q != '0);
    req_ready = (st == S_IDLE);
    dn_valid  = (st == S_RDREQ) || (st == S_WRREQ);
    dn_write  = (st == S_WRREQ);
    dn_addr   = op_addr;
    dn_wdata  = op_wdata;
    gap_start = (st == S_WRREQ) && dn_ready;
  end

  sbw_shadow u_shadow (
    .clk      (clk),
    .rst_n    (rst_n),
    .blk_we   (blk_we),
    .cmd_we   (cmd_we),
    .blk_clr  (blk_clr),
    .lane     (req_addr[1:0]),
    .val      (req_wdata),
    .blk_q    (blk_q),
    .cmd_q    (cmd_q),
    .cmd_next (cmd_next)
  );

  sbw_gap_timer #(
    .CYC_PER_US  (CYC_PER_US),
    .KHZ_W       (KHZ_W),
    .SLOW_KHZ    (SLOW_KHZ),
    .GAP_PERIODS (GAP_PERIODS),
    .ZERO_KHZ_US (ZERO_KHZ_US)
  ) u_gap (
    .clk   (clk),
    .rst_n (rst_n),
    .start (gap_start),
    .khz   (card_khz),
    .busy  (gap_busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      op_addr   <= '0;
      op_lane   <= '0;
      op_size   <= SZ_WORD;
      op_wdata  <= '0;
      op_rmw    <= 1'b0;
      nxt_pend  <= 1'b0;
      nxt_data  <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        S_IDLE: if (accept) begin
          op_addr  <= align;
          op_lane  <= req_addr[1:0];
          op_size  <= sz_in;
          op_wdata <= req_wdata;
          op_rmw   <= 1'b0;
          if (!req_write) begin
            st <= S_RDREQ;
          end else if (sz_in == SZ_WORD) begin
            st <= S_WRREQ;
          end else if (hit_blk || hit_tm) begin
            st <= S_IDLE;
          end else if (hit_cmd) begin
            st <= S_WRREQ;
            if (blk_q != '0) begin
              op_addr  <= BS_AL;
              op_wdata <= blk_q;
              nxt_pend <= 1'b1;
              nxt_data <= cmd_next;
            end else begin
              op_wdata <= cmd_next;
            end
          end else begin
            op_rmw <= 1'b1;
            st     <= S_RDREQ;
          end
        end
        S_RDREQ: if (dn_ready) st <= S_RDWAIT;
        S_RDWAIT: if (dn_rvalid) begin
          if (op_rmw) begin
            op_wdata <= merge_lane(dn_rdata, op_wdata, op_lane, op_size);
            st       <= S_WRREQ;
          end else begin
            rsp_valid <= 1'b1;
            rsp_rdata <= pick_lane(dn_rdata, op_lane, op_size);
            st        <= S_IDLE;
          end
        end
        S_WRREQ: if (dn_ready) st <= S_GAP;
        S_GAP: if (!gap_busy) begin
          if (nxt_pend) begin
            op_addr  <= CM_AL;
            op_wdata <= nxt_data;
            nxt_pend <= 1'b0;
            st       <= S_WRREQ;
          end else begin
            st <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sbw_checker.sv
module sbw_checker #(
  parameter int unsigned AW            = 8,
  parameter int unsigned BLK_SIZE_OFS  = 'h04,
  parameter int unsigned BLK_CNT_OFS   = 'h06,
  parameter int unsigned XFER_MODE_OFS = 'h0C
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          req_write,
  input logic [1:0]    req_size,
  input logic [AW-1:0] req_addr,
  input logic          dn_valid,
  input logic          dn_ready,
  input logic          dn_write,
  input logic [AW-1:0] dn_addr,
  input logic [31:0]   dn_wdata,
  input logic          dn_rvalid,
  input logic          rsp_valid,
  input logic          gap_busy
);
  logic shadow_hit;
  assign shadow_hit = req_valid && req_ready && req_write && (req_size == 2'd1) &&
                      ((req_addr == AW'(BLK_SIZE_OFS)) || (req_addr == AW'(BLK_CNT_OFS)) ||
                       (req_addr == AW'(XFER_MODE_OFS)));

  // R3 / R4: shadowed writes stay local
  a_r3_shadow_no_traffic: assert property (@(posedge clk) disable iff (!rst_n)
    shadow_hit |=> (!dn_valid && req_ready));

  // R9: quiet downstream while the spacing timer runs
  a_r9_quiet_gap: assert property (@(posedge clk) disable iff (!rst_n)
    gap_busy |-> !dn_valid);

  // R10: downstream request held until taken
  a_r10_dn_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_addr) && $stable(dn_write) && $stable(dn_wdata)));

  // R10: no downstream traffic while idle
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !dn_valid);

  // R2: a response follows downstream read data
  a_r2_rsp_after_data: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(dn_rvalid));
endmodule

bind subword_wr_bridge sbw_checker #(
  .AW            (AW),
  .BLK_SIZE_OFS  (BLK_SIZE_OFS),
  .BLK_CNT_OFS   (BLK_CNT_OFS),
  .XFER_MODE_OFS (XFER_MODE_OFS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_write (req_write),
  .req_size  (req_size),
  .req_addr  (req_addr),
  .dn_valid  (dn_valid),
  .dn_ready  (dn_ready),
  .dn_write  (dn_write),
  .dn_addr   (dn_addr),
  .dn_wdata  (dn_wdata),
  .dn_rvalid (dn_rvalid),
  .rsp_valid (rsp_valid),
  .gap_busy  (gap_busy)
);

// File: tb/sim_subword_wr_bridge.sv
`timescale 1ns/1ps
module sim_subword_wr_bridge;
  localparam int AW = 8;
  localparam int C  = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_write = 0;
  logic [1:0] req_size = 0;
  logic [AW-1:0] req_addr = 0;
  logic [31:0] req_wdata = 0;
  logic req_ready, rsp_valid, dn_valid, dn_write;
  logic [31:0] rsp_rdata, dn_wdata;
  logic [AW-1:0] dn_addr;
  logic dn_ready = 0, dn_rvalid = 0;
  logic [31:0] dn_rdata = 0;
  logic [15:0] card_khz = 16'd1000;

  always #2.5 clk = ~clk;

  subword_wr_bridge #(.AW(AW), .CYC_PER_US(C)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .dn_valid(dn_valid), .dn_ready(dn_ready),
    .dn_write(dn_write), .dn_addr(dn_addr), .dn_wdata(dn_wdata), .dn_rvalid(dn_rvalid),
    .dn_rdata(dn_rdata), .card_khz(card_khz));

  int n_chk = 0, n_fail = 0;
  logic [31:0] mem [0:63];
  logic [31:0] blk_m = 0, cmd_m = 0;

  // negedge monitor state
  logic hs_v = 0, hs_w = 0;
  logic [AW-1:0] hs_a;
  logic [31:0] hs_d;
  int wl_n = 0;
  logic [AW-1:0] wl_a [0:3];
  logic [31:0] wl_d [0:3];
  logic rsp_got = 0;
  logic [31:0] rsp_val = 0;
  logic gap_pend = 0;
  int idle_cnt = 0, gap_exp = 0;

  function automatic logic [31:0] msk(input logic [1:0] sz);
    return (sz == 0) ? 32'hff : (sz == 1) ? 32'hffff : 32'hffffffff;
  endfunction
  function automatic logic [31:0] mrg(input logic [31:0] b, input logic [31:0] v,
                                      input logic [1:0] ln, input logic [1:0] sz);
    int sh = ln * 8;
    return (b & ~(msk(sz) << sh)) | ((v & msk(sz)) << sh);
  endfunction
  function automatic int gap_cycles(input int f);
    if (f > 400) return 0;
    if (f == 0) return 10 * C;
    return ((4000 + f - 1) / f) * C;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    hs_v = dn_valid && dn_ready && rst_n;
    hs_w = dn_write; hs_a = dn_addr; hs_d = dn_wdata;
    if (rst_n && dn_valid && gap_pend) begin
      chk(idle_cnt >= gap_exp, "R9", "gap idle cycles", idle_cnt, gap_exp);
      gap_pend = 0;
    end else if (gap_pend) idle_cnt++;
    if (hs_v && hs_w) begin
      if (wl_n < 4) begin wl_a[wl_n] = dn_addr; wl_d[wl_n] = dn_wdata; end
      wl_n++;
      gap_exp = gap_cycles(card_khz);
      gap_pend = (gap_exp > 0);
      idle_cnt = 0;
    end
    if (rsp_valid) begin rsp_got = 1; rsp_val = rsp_rdata; end
  end

  // peripheral register file
  always @(posedge clk) begin
    #1;
    dn_rvalid = 0;
    if (hs_v) begin
      if (hs_w) mem[hs_a[7:2]] = hs_d;
      else begin dn_rvalid = 1; dn_rdata = mem[hs_a[7:2]]; end
      hs_v = 0;
    end
    dn_ready = ($urandom % 4) != 0;
  end

  task automatic op(input bit wr, input logic [1:0] sz, input logic [AW-1:0] a,
                    input logic [31:0] d);
    logic [AW-1:0] al;
    logic [31:0] pre, ew [0:1];
    logic [AW-1:0] ea [0:1];
    int en;
    bit seq, is_h, shadow;
    string tag;
    logic [31:0] erd;
    bit ok;
    al = a & 8'hfc;
    pre = mem[a[7:2]];
    is_h = wr && sz == 1;
    en = 0; erd = 0; shadow = 0;
    if (!wr) begin
      tag = "R2"; erd = (pre >> (a[1:0] * 8)) & msk(sz);
    end else if (sz == 2) begin
      tag = "R8"; ea[0] = al; ew[0] = d; en = 1;
    end else if (is_h && (a == 8'h04 || a == 8'h06)) begin
      tag = "R3"; blk_m = mrg(blk_m, d, a[1:0], 1); shadow = 1;
    end else if (is_h && a == 8'h0C) begin
      tag = "R4"; cmd_m = mrg(cmd_m, d, a[1:0], 1); shadow = 1;
    end else if (is_h && a == 8'h0E) begin
      if (blk_m != 0) begin
        tag = "R5"; ea[0] = 8'h04; ew[0] = blk_m; en = 1; blk_m = 0;
      end else tag = "R6";
      ea[en] = 8'h0C; ew[en] = mrg(cmd_m, d, a[1:0], 1); en++;
    end else begin
      tag = "R7"; ea[0] = al; ew[0] = mrg(pre, d, a[1:0], sz); en = 1;
    end
    seq = !shadow;
    wl_n = 0; rsp_got = 0;
    @(posedge clk); #1;
    req_valid = 1; req_write = wr; req_size = sz; req_addr = a; req_wdata = d;
    forever begin
      @(negedge clk);
      if (req_ready) break;
    end
    @(posedge clk); #1;
    req_valid = 0;
    @(negedge clk);
    if (seq) chk(!req_ready, "R10", "ready low during sequence", {31'b0, req_ready}, 0);
    else chk(req_ready, tag, "ready stays high on shadow write", {31'b0, req_ready}, 1);
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1;
    ok = (wl_n == en);
    for (int i = 0; i < en && i < wl_n; i++)
      if (wl_a[i] != ea[i] || wl_d[i] != ew[i]) ok = 0;
    chk(ok, tag, "downstream write count", wl_n, en);
    for (int i = 0; i < en && i < wl_n; i++) begin
      chk(wl_a[i] == ea[i], tag, "write address", {24'b0, wl_a[i]}, {24'b0, ea[i]});
      chk(wl_d[i] == ew[i], tag, "write data", wl_d[i], ew[i]);
    end
    if (!wr) chk(rsp_got && rsp_val == erd, "R2", "read response", rsp_val, erd);
    else chk(!rsp_got, tag, "no response on write", {31'b0, rsp_got}, 0);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R10 watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int khz_set [0:5] = '{0, 100, 300, 400, 401, 1000};
    void'($urandom(32'd12345));
    for (int i = 0; i < 64; i++) mem[i] = {$urandom} ^ (i * 32'h01010101);
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(req_ready && !dn_valid && !rsp_valid, "R1", "reset outputs",
        {29'b0, req_ready, dn_valid, rsp_valid}, 32'h4);
    rst_n = 1;
    // R1: shadows start at zero, so a bare command is a single write
    op(1, 1, 8'h0E, 32'h0000_ABCD);
    // directed flush: R3 R4 R5
    card_khz = 16'd300;
    op(1, 1, 8'h04, 32'h0000_0200);
    op(1, 1, 8'h06, 32'h0000_0003);
    op(1, 1, 8'h0C, 32'h0000_0011);
    op(1, 1, 8'h0E, 32'h0000_1234);
    op(1, 1, 8'h0E, 32'h0000_5678);
    card_khz = 16'd0;
    op(1, 0, 8'h05, 32'h0000_00A5);   // R7 byte into a shadowed word
    op(0, 0, 8'h07, 0);               // R2 top byte
    card_khz = 16'd400;
    op(1, 2, 8'h20, 32'hDEAD_BEEF);   // R8
    op(0, 1, 8'h22, 0);               // R2 upper half
    op(1, 1, 8'h12, 32'h0000_7E57);   // R7 halfword unshadowed
    for (int n = 0; n < 260; n++) begin
      int r;
      logic [AW-1:0] a;
      logic [1:0] sz;
      if (n % 20 == 0) card_khz = khz_set[$urandom % 6];
      r = $urandom % 10;
      a = {$urandom % 64, 2'b00};
      case (r)
        0, 1: op(1, 1, ($urandom % 2) ? 8'h06 : 8'h04, $urandom);
        2: op(1, 1, 8'h0C, $urandom);
        3: op(1, 1, 8'h0E, $urandom);
        4, 5: begin
          sz = $urandom % 3;
          op(0, sz, a | ((sz == 0) ? 8'($urandom % 4) : (sz == 1) ? 8'(($urandom % 2) * 2) : 8'd0), 0);
        end
        6, 7: op(1, 0, a | 8'($urandom % 4), $urandom);
        8: op(1, 1, a | 8'(($urandom % 2) * 2), $urandom);
        default: op(1, 2, a, $urandom);
      endcase
    end
    repeat (100) @(posedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule